// File: doc/BRIEF.md
# Cycle-Count Interrupt Timer with Reload Latch

This block counts clock cycles down from a software-chosen value and raises an interrupt request when the count runs out. Software sees it as a few byte-wide write registers, selected by a 4-bit register index. Two of the registers hold the bytes of a 16-bit reload latch. A third register is the control register.

A write to the control register does three things at once. It moves the latch into the live counter, clears any pending request and sets or clears counting. Writing the latch alone never disturbs a count in progress. While counting is enabled, the counter steps down once per clock. A request is flagged whenever the enabled counter sits at zero. The flag then stays up until software writes the control register again.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write to index 0xB loads the low byte of the 16-bit reload latch from the data bus, and a write to index 0xC loads the high byte.
- R2: Writes to the latch do not alter the running counter or the time at which the request fires.
- R3: A write to index 0xA sets counting on when data bit 0 is 1 and off when it is 0; the other data bits have no effect.
- R4: A write to index 0xA copies the latch into the counter and drops `irq_o` in the following cycle (unless R7 applies).
- R5: While counting is on, the counter decreases by one every clock, modulo 2^16 (zero steps to 0xFFFF), so a reload of N>0 raises `irq_o` N+1 clocks after the control write's edge.
- R6: When the enabled counter holds zero, `irq_o` is high from the next clock.
- R7: A control write that turns counting on while the latch holds zero raises `irq_o` in the cycle right after that write.
- R8: Once high, `irq_o` stays high until the next write to index 0xA.
- R9: While counting is off, the counter holds its value and no request is raised, even at zero.
- R10: An asynchronous active-low reset clears the latch, the counter, the enable and the request; reset release takes effect two clocks later.
- R11: Writes to any index other than 0xA, 0xB and 0xC change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Cycle clock; one count step per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one write per high cycle |
| wr_addr_i | input | 4 | Register index (low nibble of the decoded address) |
| wr_data_i | input | 8 | Write data byte |
| irq_o | output | 1 | Interrupt request, active high, held until acknowledged |

## Verification
The checker assumes that the write strobe, index and data are steady around each rising edge and carry no unknown values once reset is released. It also assumes that one register write per cycle is the only way software reaches the block. The stimulus changes inputs only on falling edges and issues a single write per cycle. It holds the strobe low between writes, so each assertion sees exactly one decoded action per edge. Its latch writes land both in idle periods and in the middle of a count.

// File: rtl/cit_pkg.sv
package cit_pkg;
  // Default geometry of the timer
  localparam int unsigned CNT_W_DEF  = 16;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 4;
  // Register indices: control, then the latch bytes upward from LATCH_BASE
  localparam logic [3:0] CTRL_IDX_DEF  = 4'hA;
  localparam logic [3:0] LATCH_IDX_DEF = 4'hB;
endpackage

// File: rtl/cit_rst_sync.sv
module cit_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/cit_decode.sv
module cit_decode #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned NB        = 2,
  parameter logic [ADDR_W-1:0] CTRL_IDX  = 4'hA,
  parameter logic [ADDR_W-1:0] LATCH_IDX = 4'hB
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              ctrl_wr_o,
  output logic [NB-1:0]     byte_wr_o
);
  assign ctrl_wr_o = wr_en_i && (wr_addr_i == CTRL_IDX);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign byte_wr_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(LATCH_IDX + i));
  end
endmodule

// File: rtl/cit_latch.sv
module cit_latch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NB     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NB-1:0]        byte_wr_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [NB*DATA_W-1:0] latch_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    logic [DATA_W-1:0] lane_d;

    always_comb begin
      lane_d = data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           lane_q <= '0;
      else if (byte_wr_i[i]) lane_q <= lane_d;
    end

    assign latch_o[i*DATA_W +: DATA_W] = lane_q;
  end
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_run_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             irq_q, irq_d;
  logic             cnt_ce;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign cnt_ce  = ctrl_wr_i | run_q;

  // Next-state
  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    irq_d = irq_q;
    if (ctrl_wr_i) begin
      cnt_d = reload_i;
      run_d = ctrl_run_i;
      irq_d = ctrl_run_i && (reload_i == '0);
    end else if (run_q) begin
      if (at_zero) begin
        cnt_d = '1;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cit_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] CTRL_IDX  = CTRL_IDX_DEF,
  parameter logic [ADDR_W-1:0] LATCH_IDX = LATCH_IDX_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o
);
  localparam int unsigned NB = CNT_W / DATA_W;

  logic             rst_n_sync;
  logic             ctrl_wr;
  logic [NB-1:0]    byte_wr;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  cit_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  cit_decode #(
    .ADDR_W    (ADDR_W),
    .NB        (NB),
    .CTRL_IDX  (CTRL_IDX),
    .LATCH_IDX (LATCH_IDX)
  ) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .ctrl_wr_o (ctrl_wr),
    .byte_wr_o (byte_wr)
  );

  cit_latch #(
    .DATA_W (DATA_W),
    .NB     (NB)
  ) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .byte_wr_i (byte_wr),
    .data_i    (wr_data_i),
    .latch_o   (latch_q)
  );

  cit_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .ctrl_wr_i  (ctrl_wr),
    .ctrl_run_i (wr_data_i[0]),
    .reload_i   (latch_q),
    .cnt_o      (cnt_q),
    .run_o      (run_q),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/cit_irq_chk.sv
module cit_irq_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_IDX  = 4'hA,
  parameter logic [ADDR_W-1:0] LATCH_IDX = 4'hB
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [CNT_W-1:0]  latch_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              run_i,
  input logic              irq_i
);
  localparam int unsigned NB = CNT_W / DATA_W;

  logic          ctrl_hit;
  logic [NB-1:0] lane_hit;

  assign ctrl_hit = wr_en_i && (wr_addr_i == CTRL_IDX);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_hit[i] = wr_en_i && (wr_addr_i == ADDR_W'(LATCH_IDX + i));

    // R1
    lane_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_hit[i] |=> latch_i[i*DATA_W +: DATA_W] == $past(wr_data_i));
  end

  // R2
  latch_keeps_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_hit != '0) && !run_i |=> $stable(cnt_i));

  // R3
  run_from_bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit |=> run_i == $past(wr_data_i[0]));

  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit |=> cnt_i == $past(latch_i));

  // R4
  ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit && (latch_i != '0) |=> !irq_i);

  // R5
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !ctrl_hit && (cnt_i != '0) |=> cnt_i == $past(cnt_i) - CNT_W'(1));

  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !ctrl_hit && (cnt_i == '0) |=> cnt_i == '1);

  // R6
  zero_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !ctrl_hit && (cnt_i == '0) |=> irq_i);

  // R7
  instant_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit && wr_data_i[0] && (latch_i == '0) |=> irq_i);

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !ctrl_hit |=> irq_i);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !ctrl_hit |=> $stable(cnt_i) && !$rose(irq_i));

  // R11
  ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !ctrl_hit && (lane_hit == '0) |=> $stable(latch_i) && $stable(run_i));

  // R10
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt_i == '0) && (latch_i == '0) && !run_i && !irq_i);
endmodule

bind cyc_irq_timer cit_irq_chk #(
  .CNT_W     (CNT_W),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .CTRL_IDX  (CTRL_IDX),
  .LATCH_IDX (LATCH_IDX)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_n_sync),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .latch_i   (latch_q),
  .cnt_i     (cnt_q),
  .run_i     (run_q),
  .irq_i     (irq_o)
);

// File: tb/cyc_irq_timer_tb.sv
`timescale 1ns/100ps
module cyc_irq_timer_tb;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Reference state derived from the requirements
  logic [15:0] m_latch = '0;
  logic [15:0] m_cnt   = '0;
  logic        m_run   = 1'b0;
  logic        m_irq   = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  cyc_irq_timer u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: irq_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected value per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(irq, e, t);
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                      input string req);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    if (we && a == 4'hA) begin
      m_cnt = m_latch;
      m_run = d[0];
      m_irq = d[0] && (m_latch == 16'h0000);
    end else begin
      if (we && a == 4'hB) m_latch[7:0]  = d;
      if (we && a == 4'hC) m_latch[15:8] = d;
      if (m_run) begin
        if (m_cnt == 16'h0000) begin
          m_cnt = 16'hFFFF;
          m_irq = 1'b1;
        end else begin
          m_cnt = m_cnt - 16'd1;
        end
      end
    end
    #1;
    exp_q.push_back(m_irq);
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h00, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(irq, 1'b0, "R10 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: latch cleared by reset, so enabling fires at once (R7)
    step(1'b1, 4'hA, 8'h01, "R10 latch zero after reset");
    idle(3, "R8 sticky");

    // R1, R4, R5, R6: count of 4
    step(1'b1, 4'hB, 8'h04, "R1 low byte");
    step(1'b1, 4'hC, 8'h00, "R1 high byte");
    step(1'b1, 4'hA, 8'h01, "R4 reload and ack");
    idle(8, "R6 fire at zero");

    // R9: disabled at zero holds without firing
    step(1'b1, 4'hB, 8'h00, "R8 latch write keeps irq");
    step(1'b1, 4'hA, 8'h00, "R4 ack");
    idle(30, "R9 hold when off");

    // R3: only bit 0 enables
    step(1'b1, 4'hB, 8'h02, "R1");
    step(1'b1, 4'hA, 8'hFE, "R3 bit0 clear");
    idle(10, "R3 no count");
    step(1'b1, 4'hA, 8'h01, "R3 bit0 set");
    idle(5, "R5 short count");

    // R1: high byte matters, 0x0103 cycles
    step(1'b1, 4'hB, 8'h03, "R1");
    step(1'b1, 4'hC, 8'h01, "R1");
    step(1'b1, 4'hA, 8'h81, "R1 reload 0x0103");
    idle(270, "R1 long count");

    // R2: latch writes during a count
    step(1'b1, 4'hB, 8'h20, "R2");
    step(1'b1, 4'hC, 8'h00, "R2");
    step(1'b1, 4'hA, 8'h01, "R2 start");
    idle(5, "R2");
    step(1'b1, 4'hB, 8'h00, "R2 latch lo mid count");
    step(1'b1, 4'hC, 8'h00, "R2 latch hi mid count");
    idle(35, "R2 timing unchanged");

    // R4: reload mid count restarts the count
    step(1'b1, 4'hB, 8'h0A, "R4");
    step(1'b1, 4'hA, 8'h01, "R4 start");
    idle(4, "R4");
    step(1'b1, 4'hA, 8'h01, "R4 restart");
    idle(14, "R4 restarted count");

    // R11: foreign indices ignored (latch stays 0x000A, run stays on)
    step(1'b1, 4'hA, 8'h01, "R11 start");
    step(1'b1, 4'h0, 8'hFF, "R11 index 0");
    step(1'b1, 4'h9, 8'hFF, "R11 index 9");
    step(1'b1, 4'hD, 8'h00, "R11 index D");
    step(1'b1, 4'hF, 8'hFF, "R11 index F");
    idle(10, "R11 count unaffected");
    step(1'b1, 4'hA, 8'h01, "R11 latch unchanged");
    idle(14, "R11 reload still 0x000A");

    // R7: immediate fire on enable at zero
    step(1'b1, 4'hB, 8'h00, "R7");
    step(1'b1, 4'hA, 8'h01, "R7 instant");
    idle(4, "R5 wrap keeps irq");

    idle(2, "drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule